// File: doc/BRIEF.md
# Three-State Copy-Back Cache Block Controller

This block keeps the per-line state of a small direct-mapped data cache that runs a three-state coherency scheme: modified, exclusive, or invalid. The core presents one request at a time: load, store, flush or invalidate. Each request carries an address and two page attributes, write-through and caching-inhibited. The core holds the request steady until the controller pulses completion. Loads that hit are served from the local array. Misses are serviced over a one-transaction-at-a-time bus. On that bus the controller reads a line, reads a line with intent to modify, casts out a dirty victim, pushes a modified line for a write-through store, or makes a single-word access that bypasses the array.

There is no shared state, so every load miss fills its line as exclusive. That is still a legal subset when other caches in the system use a four-state scheme. The bus may answer any transaction with an address retry. The controller then drops that answer and presents the same transaction again. Flush and invalidate act only on the local array, and a flush writes the line back only when it is dirty. A load or store to a caching-inhibited page that hits a cached line is not defined, and callers must avoid it.

Top module: `mei_cache_ctrl`

## Requirements
- R1: After reset, every line is invalid, `busReq` and `doneValid` are low, and the first access to any line makes no cast-out.
- R2: A load (op code 0) that hits a line in state M or E returns the cached word. It makes no bus transaction, and `doneValid` is high in the cycle after the request is first sampled.
- R3: A load miss issues a line read (command 0) at the line address, which is the request address with its word-select bits cleared. It returns the requested word of the fetched line and leaves the line exclusive, so a following load to it hits.
- R4: When `busRetry` is high together with `busAck`, the controller discards that response. It keeps `busReq` high with the same command and address until an acknowledge arrives without retry.
- R5: A store (op code 1) to a copy-back page that hits writes the word with no bus transaction. The line ends in M, whether it was in E or already in M.
- R6: A store to a write-through page that hits writes the word first. It then pushes the whole updated line (command 3) to the line address and leaves the line's state unchanged, so an M line stays M.
- R7: A store miss on a copy-back page issues a read-with-intent-to-modify (command 1). It merges the store word into the fetched line and marks the line M.
- R8: Before a line fill replaces a line that is in M, the controller casts that line out with command 2, at the old tag's line address and with the old data.
- R9: A flush (op code 2) that hits a line in M casts it out with command 2 and then invalidates it. A flush that hits a line in E invalidates it with no bus transaction. An invalidate (op code 3) that hits drops the line with no write-back.
- R10: A load or store that misses on a caching-inhibited page issues a single-word read (command 4) or write (command 5) at the full address, using the low word of the bus data. It allocates no line.
- R11: A store miss on a write-through, cacheable page issues a single-word write (command 5) and allocates no line.
- R12: Only one bus transaction is in flight at a time. While `busReq` is high and `busAck` is low, the command and address stay unchanged.
- R13: `doneValid` is a one-cycle pulse. The core holds the request fields stable from the moment it asserts `reqValid` until it sees that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Core request present; held until `doneValid` |
| reqOp | input | 2 | 0 load, 1 store, 2 flush, 3 invalidate |
| reqAddr | input | ADDR_W | Word address: tag, line index, word select (low bits) |
| reqWdata | input | DATA_W | Store data |
| reqWt | input | 1 | Page is write-through |
| reqCi | input | 1 | Page is caching-inhibited |
| doneValid | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Load data, valid with `doneValid` |
| busReq | output | 1 | Bus transaction requested |
| busCmd | output | 3 | 0 read, 1 RWITM, 2 cast-out, 3 push, 4 single read, 5 single write |
| busAddr | output | ADDR_W | Transaction address |
| busWdata | output | WORDS*DATA_W | Line write data; word 0 in the low bits |
| busRdata | input | WORDS*DATA_W | Line or single-word read data |
| busAck | input | 1 | Transaction answered this cycle |
| busRetry | input | 1 | Answer is an address retry; sampled with `busAck` |

## Verification
A request that needs no bus traffic completes with `doneValid` one cycle after it is first sampled. The bench drives at a falling edge and requires the pulse at the very next falling edge. Any other request completes one cycle after the acknowledge of its last transaction. The bench therefore logs every acknowledged transaction at the falling edge where it answers it, and waits for the pulse before it compares the log. Retried entries must be followed by an identical reissue. The remaining entries must match the predicted command, address and write data in order. Hidden line state, such as an E line turning into M or an M line surviving a push, is read out through the bus traffic of later requests. Examples are a cast-out on a conflicting fill and a cast-out on a flush.

// File: rtl/mei_pkg.sv
`timescale 1ns/1ps
package mei_pkg;

  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_E = 2'd1,
    ST_M = 2'd2
  } mei_t;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_FLUSH = 2'd2,
    OP_INVAL = 2'd3
  } op_t;

  typedef enum logic [2:0] {
    BC_READ    = 3'd0,
    BC_RWITM   = 3'd1,
    BC_CASTOUT = 3'd2,
    BC_PUSH    = 3'd3,
    BC_SREAD   = 3'd4,
    BC_SWRITE  = 3'd5
  } bcmd_t;

  typedef enum logic [1:0] {
    CAP_NONE       = 2'd0,
    CAP_LINE       = 2'd1,
    CAP_BUS_LINE   = 2'd2,
    CAP_BUS_SINGLE = 2'd3
  } cap_t;

  typedef struct packed {
    logic fillLine;
    logic writeWord;
    logic stateWe;
    mei_t stateVal;
    cap_t capSel;
  } strobe_t;

endpackage

// File: rtl/mei_datapath.sv
`timescale 1ns/1ps
module mei_datapath
  import mei_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16,
  parameter int LINES  = 4,
  parameter int WORDS  = 2,
  localparam int IDX_W  = $clog2(LINES),
  localparam int WSEL_W = $clog2(WORDS),
  localparam int TAG_W  = ADDR_W - IDX_W - WSEL_W,
  localparam int LINE_W = WORDS * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [IDX_W-1:0]  lineIdx,
  input  logic [TAG_W-1:0]  reqTag,
  input  logic [WSEL_W-1:0] wordSel,
  input  logic [DATA_W-1:0] wdata,
  input  logic [LINE_W-1:0] busRdata,
  output mei_t              curState,
  output logic [TAG_W-1:0]  curTag,
  output logic [LINE_W-1:0] curLine,
  output logic [DATA_W-1:0] rdata
);

  logic [LINE_W-1:0] dataArr [LINES];
  logic [TAG_W-1:0]  tagArr  [LINES];
  mei_t              stateArr[LINES];

  logic [LINE_W-1:0] baseLine;
  logic [LINE_W-1:0] newLine;

  // Fill data and a store word merge in the same cycle on an RWITM fill.
  always_comb begin
    baseLine = strb.fillLine ? busRdata : dataArr[lineIdx];
    newLine  = baseLine;
    if (strb.writeWord) begin
      newLine[wordSel*DATA_W +: DATA_W] = wdata;
    end
  end

  for (genvar g = 0; g < LINES; g++) begin : gLine
    logic lineSel;
    assign lineSel = (lineIdx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (lineSel && (strb.fillLine || strb.writeWord)) begin
        dataArr[g] <= newLine;
      end
    end

    always_ff @(posedge clk) begin
      if (lineSel && strb.fillLine) begin
        tagArr[g] <= reqTag;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stateArr[g] <= ST_I;
      end else if (lineSel && strb.stateWe) begin
        stateArr[g] <= strb.stateVal;
      end
    end
  end

  assign curState = stateArr[lineIdx];
  assign curTag   = tagArr[lineIdx];
  assign curLine  = dataArr[lineIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdata <= '0;
    end else begin
      case (strb.capSel)
        CAP_LINE:       rdata <= dataArr[lineIdx][wordSel*DATA_W +: DATA_W];
        CAP_BUS_LINE:   rdata <= busRdata[wordSel*DATA_W +: DATA_W];
        CAP_BUS_SINGLE: rdata <= busRdata[DATA_W-1:0];
        default:        rdata <= rdata;
      endcase
    end
  end

  AST_FILL_LEAVES_VALID: assert property (@(posedge clk) disable iff (!rstN)
    strb.fillLine |=> stateArr[$past(lineIdx)] != ST_I); // R3

  AST_STORE_LEAVES_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (strb.writeWord && strb.stateWe) |=> stateArr[$past(lineIdx)] == ST_M); // R5

endmodule

// File: rtl/mei_ctrl.sv
`timescale 1ns/1ps
module mei_ctrl
  import mei_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int IDX_W  = 2,
  parameter int WSEL_W = 1,
  localparam int TAG_W = ADDR_W - IDX_W - WSEL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWt,
  input  logic              reqCi,
  input  mei_t              curState,
  input  logic [TAG_W-1:0]  curTag,
  input  logic              busAck,
  input  logic              busRetry,
  output strobe_t           strb,
  output logic              busReq,
  output bcmd_t             busCmd,
  output logic [ADDR_W-1:0] busAddr,
  output logic              doneValid
);

  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_CAST   = 3'd1,
    S_FILL   = 3'd2,
    S_PUSH   = 3'd3,
    S_SINGLE = 3'd4,
    S_RESP   = 3'd5
  } fsm_t;

  fsm_t state, nxt;

  op_t               op;
  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic [ADDR_W-1:0] lineAddr;
  logic [ADDR_W-1:0] victimAddr;
  logic              hit;
  logic              accepted;

  assign op         = op_t'(reqOp);
  assign idx        = reqAddr[WSEL_W +: IDX_W];
  assign tag        = reqAddr[ADDR_W-1 -: TAG_W];
  assign lineAddr   = {tag, idx, {WSEL_W{1'b0}}};
  assign victimAddr = {curTag, idx, {WSEL_W{1'b0}}};
  assign hit        = (curState != ST_I) && (curTag == tag);
  assign accepted   = busAck && !busRetry;

  always_comb begin
    nxt     = state;
    strb    = '0;
    busReq  = 1'b0;
    busCmd  = BC_READ;
    busAddr = lineAddr;
    case (state)
      S_IDLE: begin
        if (reqValid) begin
          if (reqCi && (op == OP_LOAD || op == OP_STORE)) begin
            nxt = S_SINGLE;
          end else begin
            case (op)
              OP_LOAD: begin
                if (hit) begin
                  strb.capSel = CAP_LINE;
                  nxt = S_RESP;
                end else if (curState == ST_M) begin
                  nxt = S_CAST;
                end else begin
                  nxt = S_FILL;
                end
              end
              OP_STORE: begin
                if (hit) begin
                  strb.writeWord = 1'b1;
                  if (reqWt) begin
                    nxt = S_PUSH;
                  end else begin
                    strb.stateWe  = 1'b1;
                    strb.stateVal = ST_M;
                    nxt = S_RESP;
                  end
                end else if (reqWt) begin
                  nxt = S_SINGLE;
                end else if (curState == ST_M) begin
                  nxt = S_CAST;
                end else begin
                  nxt = S_FILL;
                end
              end
              OP_FLUSH: begin
                if (hit && curState == ST_M) begin
                  nxt = S_CAST;
                end else begin
                  strb.stateWe  = hit;
                  strb.stateVal = ST_I;
                  nxt = S_RESP;
                end
              end
              default: begin
                strb.stateWe  = hit;
                strb.stateVal = ST_I;
                nxt = S_RESP;
              end
            endcase
          end
        end
      end
      S_CAST: begin
        busReq  = 1'b1;
        busCmd  = BC_CASTOUT;
        busAddr = victimAddr;
        if (accepted) begin
          if (op == OP_FLUSH) begin
            strb.stateWe  = 1'b1;
            strb.stateVal = ST_I;
            nxt = S_RESP;
          end else begin
            nxt = S_FILL;
          end
        end
      end
      S_FILL: begin
        busReq = 1'b1;
        busCmd = (op == OP_STORE) ? BC_RWITM : BC_READ;
        if (accepted) begin
          strb.fillLine = 1'b1;
          strb.stateWe  = 1'b1;
          if (op == OP_STORE) begin
            strb.writeWord = 1'b1;
            strb.stateVal  = ST_M;
          end else begin
            strb.stateVal = ST_E;
            strb.capSel   = CAP_BUS_LINE;
          end
          nxt = S_RESP;
        end
      end
      S_PUSH: begin
        busReq = 1'b1;
        busCmd = BC_PUSH;
        if (accepted) begin
          nxt = S_RESP;
        end
      end
      S_SINGLE: begin
        busReq  = 1'b1;
        busCmd  = (op == OP_LOAD) ? BC_SREAD : BC_SWRITE;
        busAddr = reqAddr;
        if (accepted) begin
          if (op == OP_LOAD) begin
            strb.capSel = CAP_BUS_SINGLE;
          end
          nxt = S_RESP;
        end
      end
      default: begin
        nxt = S_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
    end else begin
      state <= nxt;
    end
  end

  assign doneValid = (state == S_RESP);

  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busAck) |=> (busReq && $stable(busCmd) && $stable(busAddr))); // R12

  AST_RETRY_REISSUE: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busAck && busRetry) |=> (busReq && $stable(busCmd) && $stable(busAddr))); // R4

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid); // R13

  AST_CAST_THEN_FILL: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busCmd == BC_CASTOUT && accepted && op != OP_FLUSH)
      |=> (busReq && (busCmd == BC_READ || busCmd == BC_RWITM))); // R8

  AST_HIT_NO_BUS: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && reqValid && !reqCi && op == OP_LOAD && hit)
      |=> (doneValid && !busReq)); // R2

endmodule

// File: rtl/mei_cache_ctrl.sv
`timescale 1ns/1ps
module mei_cache_ctrl
  import mei_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16,
  parameter int LINES  = 4,
  parameter int WORDS  = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      reqValid,
  input  logic [1:0]                reqOp,
  input  logic [ADDR_W-1:0]         reqAddr,
  input  logic [DATA_W-1:0]         reqWdata,
  input  logic                      reqWt,
  input  logic                      reqCi,
  output logic                      doneValid,
  output logic [DATA_W-1:0]         rdata,
  output logic                      busReq,
  output logic [2:0]                busCmd,
  output logic [ADDR_W-1:0]         busAddr,
  output logic [WORDS*DATA_W-1:0]   busWdata,
  input  logic [WORDS*DATA_W-1:0]   busRdata,
  input  logic                      busAck,
  input  logic                      busRetry
);

  localparam int IDX_W  = $clog2(LINES);
  localparam int WSEL_W = $clog2(WORDS);
  localparam int TAG_W  = ADDR_W - IDX_W - WSEL_W;
  localparam int LINE_W = WORDS * DATA_W;

  strobe_t           strb;
  mei_t              curState;
  logic [TAG_W-1:0]  curTag;
  logic [LINE_W-1:0] curLine;
  bcmd_t             busCmdT;

  mei_ctrl #(
    .ADDR_W(ADDR_W),
    .IDX_W (IDX_W),
    .WSEL_W(WSEL_W)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqOp    (reqOp),
    .reqAddr  (reqAddr),
    .reqWt    (reqWt),
    .reqCi    (reqCi),
    .curState (curState),
    .curTag   (curTag),
    .busAck   (busAck),
    .busRetry (busRetry),
    .strb     (strb),
    .busReq   (busReq),
    .busCmd   (busCmdT),
    .busAddr  (busAddr),
    .doneValid(doneValid)
  );

  mei_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .LINES (LINES),
    .WORDS (WORDS)
  ) uData (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .lineIdx (reqAddr[WSEL_W +: IDX_W]),
    .reqTag  (reqAddr[ADDR_W-1 -: TAG_W]),
    .wordSel (reqAddr[WSEL_W-1:0]),
    .wdata   (reqWdata),
    .busRdata(busRdata),
    .curState(curState),
    .curTag  (curTag),
    .curLine (curLine),
    .rdata   (rdata)
  );

  assign busCmd   = busCmdT;
  assign busWdata = (busCmdT == BC_SWRITE) ? {{(LINE_W-DATA_W){1'b0}}, reqWdata} : curLine;

endmodule

// File: tb/sim_mei_cache_ctrl.sv
`timescale 1ns/1ps
module sim_mei_cache_ctrl;

  localparam int ADDR_W = 10;
  localparam int DATA_W = 16;
  localparam int LINES  = 4;
  localparam int WORDS  = 2;
  localparam int LINE_W = WORDS * DATA_W;

  logic              clk = 1'b0;
  logic              rstN;
  logic              reqValid;
  logic [1:0]        reqOp;
  logic [ADDR_W-1:0] reqAddr;
  logic [DATA_W-1:0] reqWdata;
  logic              reqWt;
  logic              reqCi;
  logic              doneValid;
  logic [DATA_W-1:0] rdata;
  logic              busReq;
  logic [2:0]        busCmd;
  logic [ADDR_W-1:0] busAddr;
  logic [LINE_W-1:0] busWdata;
  logic [LINE_W-1:0] busRdata;
  logic              busAck;
  logic              busRetry;

  always #10 clk = ~clk;

  mei_cache_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES), .WORDS(WORDS)
  ) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .reqWt(reqWt), .reqCi(reqCi), .doneValid(doneValid), .rdata(rdata),
    .busReq(busReq), .busCmd(busCmd), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .busAck(busAck), .busRetry(busRetry)
  );

  int nChecks = 0;
  int nErrors = 0;
  bit finished = 0;

  logic [DATA_W-1:0] mem [1024];
  int                mState [LINES];
  logic [6:0]        mTag   [LINES];
  logic [LINE_W-1:0] mLine  [LINES];

  int                logN = 0;
  int                logCmd   [16];
  logic [ADDR_W-1:0] logAddr  [16];
  logic [LINE_W-1:0] logData  [16];
  bit                logRetry [16];

  int waitCnt = 0;
  int consec = 0;
  int forceRetry = 0;
  bit randRetry = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [LINE_W-1:0] putWord(input logic [LINE_W-1:0] ln, input int w,
                                                 input logic [DATA_W-1:0] d);
    logic [LINE_W-1:0] r = ln;
    r[w*DATA_W +: DATA_W] = d;
    return r;
  endfunction

  function automatic logic [LINE_W-1:0] memLine(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] b = {a[ADDR_W-1:1], 1'b0};
    return {mem[b + 1], mem[b]};
  endfunction

  // Bus responder: answers at falling edges, logs every answered transaction.
  always @(negedge clk) begin
    if (!rstN) begin
      busAck = 0; busRetry = 0; busRdata = '0; waitCnt = 0; consec = 0;
    end else if (busAck) begin
      busAck = 0; busRetry = 0;
    end else if (busReq) begin
      if (waitCnt > 0) begin
        waitCnt--;
      end else begin
        bit rt;
        logic [LINE_W-1:0] ln;
        logic [ADDR_W-1:0] b;
        b = {busAddr[ADDR_W-1:1], 1'b0};
        if (forceRetry > 0) begin
          rt = 1; forceRetry--;
        end else begin
          rt = randRetry && consec < 2 && ($urandom % 4 == 0);
        end
        consec = rt ? consec + 1 : 0;
        ln = (busCmd == 3'd4) ? {16'h0, mem[busAddr]} : memLine(busAddr);
        busRdata = rt ? ~ln : ln;
        if (!rt) begin
          case (busCmd)
            3'd2, 3'd3: begin mem[b] = busWdata[15:0]; mem[b + 1] = busWdata[31:16]; end
            3'd5: mem[busAddr] = busWdata[15:0];
            default: ;
          endcase
        end
        if (logN < 16) begin
          logCmd[logN] = busCmd; logAddr[logN] = busAddr;
          logData[logN] = busWdata; logRetry[logN] = rt;
          logN++;
        end
        busAck = 1; busRetry = rt;
        waitCnt = $urandom % 3;
      end
    end
  end

  task automatic doReq(input int op, input logic [ADDR_W-1:0] addr, input logic [DATA_W-1:0] wd,
                       input bit wt, input bit ci);
    int idx = int'(addr[2:1]);
    int w = int'(addr[0]);
    logic [6:0] tg = addr[9:3];
    logic [ADDR_W-1:0] la = {addr[9:1], 1'b0};
    logic [ADDR_W-1:0] va = {mTag[idx], addr[2:1], 1'b0};
    bit hit = (mState[idx] != 0) && (mTag[idx] == tg);
    logic [LINE_W-1:0] fetched = memLine(addr);
    int eN = 0;
    int eCmd[4];
    logic [ADDR_W-1:0] eAddr[4];
    logic [LINE_W-1:0] eData[4];
    bit eHas[4];
    string eTag[4];
    bit expRd = 0;
    logic [DATA_W-1:0] rdExp = '0;
    string t = "R2";
    int nState = mState[idx];
    logic [6:0] nTag = mTag[idx];
    logic [LINE_W-1:0] nLine = mLine[idx];
    int cyc = 0;
    int accN = 0;
    int aIdx[16];

    if (ci && op < 2) begin
      t = "R10";
      eCmd[0] = (op == 0) ? 4 : 5; eAddr[0] = addr; eData[0] = {16'h0, wd};
      eHas[0] = (op == 1); eTag[0] = "R10"; eN = 1;
      if (op == 0) begin expRd = 1; rdExp = mem[addr]; end
    end else if (op == 0) begin
      if (hit) begin
        t = "R2"; expRd = 1; rdExp = mLine[idx][w*DATA_W +: DATA_W];
      end else begin
        t = "R3";
        if (mState[idx] == 2) begin
          eCmd[eN] = 2; eAddr[eN] = va; eData[eN] = mLine[idx]; eHas[eN] = 1; eTag[eN] = "R8"; eN++;
        end
        eCmd[eN] = 0; eAddr[eN] = la; eHas[eN] = 0; eTag[eN] = "R3"; eN++;
        expRd = 1; rdExp = fetched[w*DATA_W +: DATA_W];
        nState = 1; nTag = tg; nLine = fetched;
      end
    end else if (op == 1) begin
      if (hit && !wt) begin
        t = "R5"; nLine = putWord(mLine[idx], w, wd); nState = 2;
      end else if (hit) begin
        t = "R6"; nLine = putWord(mLine[idx], w, wd);
        eCmd[0] = 3; eAddr[0] = la; eData[0] = nLine; eHas[0] = 1; eTag[0] = "R6"; eN = 1;
      end else if (wt) begin
        t = "R11";
        eCmd[0] = 5; eAddr[0] = addr; eData[0] = {16'h0, wd}; eHas[0] = 1; eTag[0] = "R11"; eN = 1;
      end else begin
        t = "R7";
        if (mState[idx] == 2) begin
          eCmd[eN] = 2; eAddr[eN] = va; eData[eN] = mLine[idx]; eHas[eN] = 1; eTag[eN] = "R8"; eN++;
        end
        eCmd[eN] = 1; eAddr[eN] = la; eHas[eN] = 0; eTag[eN] = "R7"; eN++;
        nState = 2; nTag = tg; nLine = putWord(fetched, w, wd);
      end
    end else begin
      t = "R9";
      if (hit) begin
        if (op == 2 && mState[idx] == 2) begin
          eCmd[0] = 2; eAddr[0] = la; eData[0] = mLine[idx]; eHas[0] = 1; eTag[0] = "R9"; eN = 1;
        end
        nState = 0;
      end
    end

    logN = 0;
    @(negedge clk);
    reqValid = 1; reqOp = 2'(op); reqAddr = addr; reqWdata = wd; reqWt = wt; reqCi = ci;
    do begin
      @(negedge clk);
      cyc++;
    end while (!doneValid && cyc < 200);
    check(cyc < 200, t, "watchdog on completion", 64'(cyc), 64'd0);
    reqValid = 0;
    if (expRd) check(rdata == rdExp, t, "load data", 64'(rdata), 64'(rdExp));
    if (eN == 0) check(cyc == 1, (t == "R2") ? "R2" : t, "completion latency", 64'(cyc), 64'd1);

    for (int i = 0; i < logN; i++) begin
      if (logRetry[i]) begin
        check(i + 1 < logN && logCmd[i + 1] == logCmd[i] && logAddr[i + 1] == logAddr[i],
              "R4", "reissue after retry", 64'(logCmd[i]), 64'(logAddr[i]));
      end else if (accN < 16) begin
        aIdx[accN] = i; accN++;
      end
    end
    check(accN == eN, t, "transaction count", 64'(accN), 64'(eN));
    for (int k = 0; k < eN && k < accN; k++) begin
      check(logCmd[aIdx[k]] == eCmd[k], eTag[k], "bus command", 64'(logCmd[aIdx[k]]), 64'(eCmd[k]));
      check(logAddr[aIdx[k]] == eAddr[k], eTag[k], "bus address", 64'(logAddr[aIdx[k]]), 64'(eAddr[k]));
      if (eHas[k]) begin
        logic [LINE_W-1:0] got = (eCmd[k] == 5) ? {16'h0, logData[aIdx[k]][15:0]} : logData[aIdx[k]];
        check(got == eData[k], eTag[k], "bus write data", 64'(got), 64'(eData[k]));
      end
    end
    mState[idx] = nState; mTag[idx] = nTag; mLine[idx] = nLine;
    if (op < 2 && ci) begin
      mState[idx] = mState[idx];
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nErrors++;
      nChecks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5EED));
    for (int i = 0; i < 1024; i++) mem[i] = 16'(i * 16'h9E37 + 16'h0155);
    for (int i = 0; i < LINES; i++) begin mState[i] = 0; mTag[i] = '0; mLine[i] = '0; end
    rstN = 0; reqValid = 0; reqOp = 0; reqAddr = '0; reqWdata = '0; reqWt = 0; reqCi = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check(busReq == 1'b0, "R1", "busReq after reset", 64'(busReq), 64'd0);
    check(doneValid == 1'b0, "R1", "doneValid after reset", 64'(doneValid), 64'd0);

    // R1: the first access to every line only fills; R3 fill as E then R2 hit
    for (int i = 0; i < LINES; i++) begin
      doReq(0, {7'd0, 2'(i), 1'b0}, 16'h0, 0, 0);
      check(logN == 1 && logCmd[0] == 0, "R1", "first touch without cast-out", 64'(logN), 64'd1);
    end
    doReq(0, {7'd0, 2'd0, 1'b1}, 16'h0, 0, 0);           // R2 hit on E
    // R4: forced retries on a fill
    forceRetry = 2;
    doReq(0, {7'd1, 2'd1, 1'b1}, 16'h0, 0, 0);
    check(logN == 3, "R4", "read issued three times", 64'(logN), 64'd3);
    // R5: E to M silently, proven by R8 cast-out on a conflicting load
    doReq(1, {7'd1, 2'd1, 1'b0}, 16'hA5A5, 0, 0);
    doReq(0, {7'd1, 2'd1, 1'b0}, 16'h0, 0, 0);           // R2 hit on M
    doReq(0, {7'd2, 2'd1, 1'b0}, 16'h0, 0, 0);           // R8 cast-out then R3 read
    // R6: write-through hit on M keeps M: following flush must cast out (R9)
    doReq(1, {7'd2, 2'd1, 1'b1}, 16'h1111, 0, 0);
    forceRetry = 1;
    doReq(1, {7'd2, 2'd1, 1'b0}, 16'h2222, 1, 0);
    doReq(2, {7'd2, 2'd1, 1'b0}, 16'h0, 0, 0);
    doReq(0, {7'd2, 2'd1, 1'b1}, 16'h0, 0, 0);           // R9: line now I, plain read
    // R9: flush of an E line, no bus traffic, then miss
    doReq(2, {7'd0, 2'd2, 1'b0}, 16'h0, 0, 0);
    doReq(0, {7'd0, 2'd2, 1'b0}, 16'h0, 0, 0);
    // R7 then R9 invalidate drops dirty data
    doReq(1, {7'd3, 2'd3, 1'b1}, 16'hBEEF, 0, 0);
    doReq(3, {7'd3, 2'd3, 1'b0}, 16'h0, 0, 0);
    doReq(0, {7'd3, 2'd3, 1'b1}, 16'h0, 0, 0);
    // R10 caching-inhibited, R11 write-through store miss
    doReq(0, {7'd8, 2'd0, 1'b1}, 16'h0, 0, 1);
    doReq(1, {7'd8, 2'd0, 1'b1}, 16'h7777, 0, 1);
    doReq(0, {7'd8, 2'd0, 1'b1}, 16'h0, 0, 1);
    doReq(1, {7'd2, 2'd0, 1'b0}, 16'h4242, 1, 0);
    doReq(0, {7'd2, 2'd0, 1'b0}, 16'h0, 0, 0);

    // Constrained random mix with random retries (R12, R13 by assertion and pacing)
    randRetry = 1;
    for (int n = 0; n < 400; n++) begin
      int r = $urandom % 100;
      int op;
      bit ci = ($urandom % 10 == 0);
      bit wt = ($urandom % 4 == 0);
      logic [6:0] tg = ci ? 7'(8 + $urandom % 4) : 7'($urandom % 4);
      logic [ADDR_W-1:0] a = {tg, 2'($urandom % 4), 1'($urandom % 2)};
      if (ci) op = $urandom % 2;
      else if (r < 45) op = 0;
      else if (r < 80) op = 1;
      else if (r < 90) op = 2;
      else op = 3;
      doReq(op, a, 16'($urandom), wt, ci);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

endmodule